// File: doc/BRIEF.md
# Circulating Display Memory With Marker Overlay

This block holds complete display pictures in recirculating bit memories and turns them into a serial video bit stream. Each picture has 18432 locations. Every location holds one pair of pixels, one even and one odd. The pair is kept in two parallel lanes, one for even pixels and one for odd pixels, and both lanes advance together. There are three picture memories, and a 2-bit select picks the one that is shown and updated.

An external timing block supplies the shift pulses and decides when a line update is active. On each shift, the oldest pair of every memory is read. It is then written back unchanged, or, for the selected memory during an update, replaced by the incoming pair. The pair read from the selected memory is sent out serially: the even pixel first, then the odd pixel.

A frequency-marker input is combined with each outgoing pixel. Where the marker meets a lit pixel, the video goes dark. Where the marker meets a blank pixel, the video is lit. Each lane is built as a RAM with a wrapping pointer, not as a literal shift chain.

Top module: `circ_display_mem`

## Requirements
- R1: After reset, `videoOut` is low and the location pointer is at location 0, so the first shift after reset reads location 0.
- R2: Each shift reads the locations in ascending order. After location DEPTH-1 the next shift reads location 0 again, so the same location comes back every DEPTH shifts.
- R3: On a shift with `updateEn` low, the pair read is written back unchanged. A whole frame of DEPTH shifts with no update leaves every bit of every memory as it was.
- R4: On a shift with `updateEn` high, `evenIn`/`oddIn` are stored at that location of the selected memory. The video for that shift still shows the pair stored there before.
- R5: At the clock edge that takes a shift, `videoOut` becomes the even pixel of the pair read. At the next edge it becomes the odd pixel. Shift pulses must be at least two cycles apart.
- R6: Each output pixel is XORed with `markerIn`, sampled at the same edge. A lit pixel under the marker gives 0 (a dark line). A blank pixel under the marker gives 1.
- R7: In any cycle that does not output an even or odd pixel, `videoOut` is 0, whatever the value of `markerIn`.
- R8: `picSel` values 0, 1 and 2 choose memory 0, 1 and 2. Only the chosen memory drives video and takes updates. The others recirculate unchanged.
- R9: `picSel` = 3 chooses no memory. Both pixels read as blank, so `videoOut` equals `markerIn`, and update data is ignored by every memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| shiftEn | input | 1 | One-cycle pulse that advances all memories by one location |
| updateEn | input | 1 | Line update active: replace the pair at this shift |
| picSel | input | 2 | Picture memory select (0..2, 3 selects none) |
| evenIn | input | 1 | New even pixel for an update |
| oddIn | input | 1 | New odd pixel for an update |
| markerIn | input | 1 | Frequency-marker position for the pixel being output |
| videoOut | output | 1 | Serial video bit |

## Verification
Each of the three memories is loaded with its own arithmetic pattern. It is then circulated for a whole frame while every even and odd bit is checked. Because the patterns differ, a wrong select, a lane swap or a missed wrap shows up as a mismatch. A frame with all four marker/pixel combinations separates XOR behaviour from forcing the output high or low. A frame with no memory selected and update data all ones shows whether writes leak into any memory. A partial update, every third location of memory 1 with inverted data, shows the old value in the update frame and the new value in the next frame. The other memories are re-checked after it to confirm that they were not touched.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
  // Strobes passed from the control unit to the datapath each cycle.
  typedef struct packed {
    logic advance;   // read the oldest pair and write it back
    logic writeNew;  // replace the pair with incoming data
    logic emitEven;  // serializer phase 0
    logic emitOdd;   // serializer phase 1
  } ctrlStrobes_t;
endpackage

// File: rtl/cdm_ctrl.sv
module cdm_ctrl #(
  parameter int DEPTH  = 18432,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    shiftEn,
  input  logic                    updateEn,
  output cdm_pkg::ctrlStrobes_t   strobes,
  output logic [ADDR_W-1:0]       ptr
);
  localparam logic [ADDR_W-1:0] LAST_LOC = ADDR_W'(DEPTH - 1);

  logic oddPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr        <= '0;
      oddPending <= 1'b0;
    end else begin
      oddPending <= shiftEn;
      if (shiftEn) begin
        ptr <= (ptr == LAST_LOC) ? '0 : ptr + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.advance  = shiftEn;
    strobes.writeNew = shiftEn & updateEn;
    strobes.emitEven = shiftEn;
    strobes.emitOdd  = oddPending;
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= LAST_LOC);                                             // R2
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn && ptr == LAST_LOC |=> ptr == '0);                    // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEn |=> $stable(ptr));                                   // R3
  AST_SHIFT_GAP: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> !shiftEn);                                        // R5
endmodule

// File: rtl/cdm_lane.sv
module cdm_lane #(
  parameter int DEPTH     = 18432,
  parameter int WORD_BITS = 32,
  parameter int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              wrBit,
  output logic              rdBit
);
  localparam int BIT_W  = $clog2(WORD_BITS);
  localparam int WORDS  = DEPTH / WORD_BITS;
  localparam int WIDX_W = ADDR_W - BIT_W;

  logic [WORD_BITS-1:0] mem [WORDS];
  logic [WIDX_W-1:0]    wordIdx;
  logic [BIT_W-1:0]     bitIdx;

  assign wordIdx = addr[ADDR_W-1:BIT_W];
  assign bitIdx  = addr[BIT_W-1:0];
  assign rdBit   = mem[wordIdx][bitIdx];

  always_ff @(posedge clk) begin
    if (wrEn) begin
      mem[wordIdx][bitIdx] <= wrBit;
    end
  end

  initial begin
    assert (DEPTH % WORD_BITS == 0 && WORD_BITS >= 2)
      else $error("lane depth must be a whole number of words");
  end
endmodule

// File: rtl/cdm_data.sv
module cdm_data #(
  parameter int DEPTH     = 18432,
  parameter int WORD_BITS = 32,
  parameter int NUM_PICS  = 3,
  parameter int ADDR_W    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cdm_pkg::ctrlStrobes_t strobes,
  input  logic [ADDR_W-1:0]     ptr,
  input  logic [1:0]            picSel,
  input  logic                  evenIn,
  input  logic                  oddIn,
  input  logic                  markerIn,
  output logic                  videoOut
);
  logic [NUM_PICS-1:0] evenRd;
  logic [NUM_PICS-1:0] oddRd;
  logic                selEven;
  logic                selOdd;
  logic                selValid;
  logic                oddHold;

  for (genvar p = 0; p < NUM_PICS; p++) begin : g_pic
    logic isSel;
    logic takeNew;
    assign isSel   = (picSel == 2'(p));
    assign takeNew = strobes.writeNew & isSel;

    cdm_lane #(.DEPTH(DEPTH), .WORD_BITS(WORD_BITS), .ADDR_W(ADDR_W)) u_even (
      .clk   (clk),
      .addr  (ptr),
      .wrEn  (strobes.advance),
      .wrBit (takeNew ? evenIn : evenRd[p]),
      .rdBit (evenRd[p])
    );
    cdm_lane #(.DEPTH(DEPTH), .WORD_BITS(WORD_BITS), .ADDR_W(ADDR_W)) u_odd (
      .clk   (clk),
      .addr  (ptr),
      .wrEn  (strobes.advance),
      .wrBit (takeNew ? oddIn : oddRd[p]),
      .rdBit (oddRd[p])
    );
  end

  assign selValid = ({1'b0, picSel} < 3'(NUM_PICS));

  always_comb begin
    selEven = 1'b0;
    selOdd  = 1'b0;
    for (int k = 0; k < NUM_PICS; k++) begin
      if (picSel == 2'(k)) begin
        selEven = evenRd[k];
        selOdd  = oddRd[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oddHold  <= 1'b0;
      videoOut <= 1'b0;
    end else begin
      if (strobes.emitEven) begin
        oddHold <= selOdd;
      end
      if (strobes.emitEven) begin
        videoOut <= selEven ^ markerIn;
      end else if (strobes.emitOdd) begin
        videoOut <= oddHold ^ markerIn;
      end else begin
        videoOut <= 1'b0;
      end
    end
  end

  AST_MARK_DARK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emitEven && selEven && markerIn |=> !videoOut);        // R6
  AST_MARK_LIT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emitEven && !selEven && markerIn |=> videoOut);        // R6
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.emitEven && !strobes.emitOdd |=> !videoOut);          // R7
  AST_NO_SEL_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emitEven && !selValid |=> videoOut == $past(markerIn)); // R9
  AST_ODD_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emitEven |=> strobes.emitOdd);                         // R5
endmodule

// File: rtl/circ_display_mem.sv
module circ_display_mem #(
  parameter int DEPTH     = 18432,
  parameter int WORD_BITS = 32,
  parameter int NUM_PICS  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       shiftEn,
  input  logic       updateEn,
  input  logic [1:0] picSel,
  input  logic       evenIn,
  input  logic       oddIn,
  input  logic       markerIn,
  output logic       videoOut
);
  localparam int ADDR_W = $clog2(DEPTH);

  cdm_pkg::ctrlStrobes_t strobes;
  logic [ADDR_W-1:0]     ptr;

  cdm_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .shiftEn  (shiftEn),
    .updateEn (updateEn),
    .strobes  (strobes),
    .ptr      (ptr)
  );

  cdm_data #(
    .DEPTH(DEPTH), .WORD_BITS(WORD_BITS), .NUM_PICS(NUM_PICS), .ADDR_W(ADDR_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .ptr      (ptr),
    .picSel   (picSel),
    .evenIn   (evenIn),
    .oddIn    (oddIn),
    .markerIn (markerIn),
    .videoOut (videoOut)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    !rstN |=> !videoOut);                                          // R1
endmodule

// File: tb/tb_circ_display_mem.sv
`timescale 1ns/1ps
module tb_circ_display_mem;
  localparam int DEPTH = 48;
  localparam int WBITS = 8;
  localparam int NPICS = 3;

  logic       clk = 1'b0;
  logic       rstN;
  logic       shiftEn, updateEn, evenIn, oddIn, markerIn;
  logic [1:0] picSel;
  logic       videoOut;

  int total = 0;
  int fails = 0;
  bit mEven [NPICS][DEPTH];
  bit mOdd  [NPICS][DEPTH];

  always #4 clk = ~clk;

  circ_display_mem #(.DEPTH(DEPTH), .WORD_BITS(WBITS), .NUM_PICS(NPICS)) dut (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .updateEn(updateEn),
    .picSel(picSel), .evenIn(evenIn), .oddIn(oddIn), .markerIn(markerIn),
    .videoOut(videoOut)
  );

  function automatic bit patE(int p, int i);
    return ((i * 5 + p * 7 + 1) % 3) == 0;
  endfunction
  function automatic bit patO(int p, int i);
    return ((i * 3 + p * 11) % 4) < 2;
  endfunction

  task automatic check(bit act, bit exp, string req, string what);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // One shift: even pixel out at the shift edge, odd pixel next, then an idle cycle.
  task automatic doShift(bit upd, bit e, bit o, bit mk0, bit mk1,
                         bit doChk, bit expE, bit expO, bit chkIdle, string req);
    shiftEn = 1'b1; updateEn = upd; evenIn = e; oddIn = o; markerIn = mk0;
    @(negedge clk);
    if (doChk) check(videoOut, expE, req, "even pixel");
    shiftEn = 1'b0; updateEn = 1'b0; markerIn = mk1;
    @(negedge clk);
    if (doChk) check(videoOut, expO, req, "odd pixel");
    markerIn = 1'b1;
    @(negedge clk);
    if (chkIdle) check(videoOut, 1'b0, "R7", "idle cycle with marker high");
    markerIn = 1'b0;
  endtask

  // Circulate one frame of a memory with no update and check each bit (R2 R3 R8).
  task automatic verifyFrame(int p, string req);
    picSel = 2'(p);
    for (int i = 0; i < DEPTH; i++)
      doShift(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, mEven[p][i], mOdd[p][i],
              (i == 5), req);
  endtask

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rstN = 1'b0; shiftEn = 1'b0; updateEn = 1'b0; evenIn = 1'b0; oddIn = 1'b0;
    markerIn = 1'b0; picSel = 2'd0;
    repeat (3) @(negedge clk);
    check(videoOut, 1'b0, "R1", "video during reset");
    rstN = 1'b1;
    @(negedge clk);
    check(videoOut, 1'b0, "R1", "video after reset");

    // Load every memory with its own pattern (R4), no checks on unknown prior content.
    for (int p = 0; p < NPICS; p++) begin
      picSel = 2'(p);
      for (int i = 0; i < DEPTH; i++) begin
        doShift(1'b1, patE(p, i), patO(p, i), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        mEven[p][i] = patE(p, i);
        mOdd[p][i]  = patO(p, i);
      end
    end

    // Circulate: location i returns every DEPTH shifts, bit-exact (R1 R2 R3 R5 R8).
    for (int p = 0; p < NPICS; p++) verifyFrame(p, "R3");
    verifyFrame(0, "R2");

    // Marker truth table over all pixel/marker combinations (R6).
    picSel = 2'd0;
    for (int i = 0; i < DEPTH; i++) begin
      bit m0 = bit'(i % 2);
      bit m1 = bit'((i / 2) % 2);
      doShift(1'b0, 1'b0, 1'b0, m0, m1, 1'b1, mEven[0][i] ^ m0, mOdd[0][i] ^ m1,
              1'b0, "R6");
    end

    // No memory selected: pixels blank, updates ignored (R9).
    picSel = 2'd3;
    for (int i = 0; i < DEPTH; i++) begin
      bit m0 = bit'((i / 3) % 2);
      bit m1 = bit'(i % 2);
      doShift(1'b1, 1'b1, 1'b1, m0, m1, 1'b1, m0, m1, 1'b0, "R9");
    end
    for (int p = 0; p < NPICS; p++) verifyFrame(p, "R9");

    // Partial update of memory 1: old value shown now, new value next frame (R4 R8).
    picSel = 2'd1;
    for (int i = 0; i < DEPTH; i++) begin
      bit upd = (i % 3) == 0;
      doShift(upd, ~mEven[1][i], ~mOdd[1][i], 1'b0, 1'b0, 1'b1,
              mEven[1][i], mOdd[1][i], 1'b0, "R4");
      if (upd) begin
        mEven[1][i] = ~mEven[1][i];
        mOdd[1][i]  = ~mOdd[1][i];
      end
    end
    verifyFrame(1, "R4");
    verifyFrame(0, "R8");
    verifyFrame(2, "R8");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule